// File: doc/BRIEF.md
# DMA Lane Reorder Stage

This block is one registered stage of a DMA data path that reorders the four byte lanes of a 32-bit beat. Three independent controls are provided. On the read side, a word-wide beat can have its two middle bytes (lanes 1 and 2) exchanged, which is an exchange inside the half-word that straddles the word's centre. On the write side, applied to data that has already been packed to the destination width, bytes can be exchanged inside each half-word, and the two half-words of a word can be exchanged.

Every control is qualified by a 2-bit width code. The read-side control uses the source width code and the write-side controls use the destination width code. A swap whose width condition is not met leaves the beat unchanged. The byte-lane enables travel with the data and are reordered lane for lane with it. Beats enter and leave through valid/ready handshakes. The controls are sampled together with the beat when it is accepted.

Top module: `dma_lane_swap`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `out_valid` is 0.
- R2: When `src_width` is 2'b10 (word) and `src_bxch` is 1, output lanes 1 and 2 (bits 15:8 and 23:16) hold input lanes 2 and 1. Lanes 0 and 3 are unchanged.
- R3: When `src_width` is 2'b00 (byte), 2'b01 (half-word) or 2'b11 (reserved), `src_bxch` has no effect.
- R4: When `dst_width` is 2'b01 or 2'b10 and `dst_bxch` is 1, lanes 0 and 1 are exchanged and lanes 2 and 3 are exchanged.
- R5: When `dst_width` is 2'b00 or 2'b11, `dst_bxch` has no effect.
- R6: `dst_hxch` exchanges lanes {1,0} with lanes {3,2} only when `dst_width` is 2'b10. Under any other width code it has no effect.
- R7: When `dst_width` is 2'b10 and both `dst_bxch` and `dst_hxch` are 1, the byte exchange is applied first and the half-word exchange second. The result is a full byte reversal: output lane k holds input lane 3-k.
- R8: The read-side exchange is applied before both write-side exchanges.
- R9: Bit k of `out_be` always belongs to output byte lane k. The enables are moved by exactly the same permutation as the data bytes.
- R10: A beat accepted on a clock edge (`in_valid` and `in_ready` both 1) is presented on the outputs with `out_valid` 1 directly after that edge.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_be` hold their values, and no beat is lost or duplicated.
- R12: `in_ready` is 1 exactly when the output register is empty or is being drained in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_width | input | 2 | Source width code: 00 byte, 01 half-word, 10 word, 11 reserved |
| src_bxch | input | 1 | Exchange middle bytes (lanes 1 and 2) of a word-wide source beat |
| dst_width | input | 2 | Destination width code, same encoding as `src_width` |
| dst_bxch | input | 1 | Exchange bytes inside each destination half-word |
| dst_hxch | input | 1 | Exchange the two half-words of a destination word |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage can accept a beat |
| in_data | input | 32 | Input beat data |
| in_be | input | 4 | Input byte-lane enables |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 32 | Reordered beat data |
| out_be | output | 4 | Reordered byte-lane enables |

## Verification
The properties assume a standard handshake on the input side: a beat is not counted as transferred unless `in_valid` and `in_ready` are both high at a clock edge. The width and exchange controls are taken as meaningful only in that transfer cycle. The bench drives all inputs just after a rising edge and holds them until the next one. It holds a beat until the beat has been accepted, and it covers every width code, including the reserved one. In the random phase `out_ready` is toggled, so the property that the output holds steady while stalled is exercised against real back-pressure.

// File: rtl/dma_swap_pkg.sv
package dma_swap_pkg;
   typedef enum logic [1:0] {
      DW_BYTE = 2'b00,
      DW_HALF = 2'b01,
      DW_WORD = 2'b10,
      DW_RSVD = 2'b11
   } dw_code_e;

   typedef enum int {
      PERM_MID  = 0,
      PERM_BYTE = 1,
      PERM_HALF = 2
   } perm_kind_e;
endpackage

// File: rtl/lane_permute.sv
module lane_permute
   import dma_swap_pkg::*;
#(
   parameter int         LANE_W = 8,
   parameter int         LANES  = 4,
   parameter perm_kind_e KIND   = PERM_MID
) (
   input  logic                     en,
   input  logic [LANES*LANE_W-1:0]  d_in,
   input  logic [LANES-1:0]         be_in,
   output logic [LANES*LANE_W-1:0]  d_out,
   output logic [LANES-1:0]         be_out
);
   localparam int DW = LANES * LANE_W;

   if (LANES != 4) begin : g_bad_lanes
      $error("lane_permute: LANES must be 4");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("lane_permute: LANE_W must be positive");
   end

   logic [DW-1:0]    swapped_d;
   logic [LANES-1:0] swapped_be;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int P = (KIND == PERM_MID)  ? ((i == 1) ? 2 : (i == 2) ? 1 : i) :
                         (KIND == PERM_BYTE) ? (i ^ 1) :
                                               (i ^ 2);
      assign swapped_d[i*LANE_W +: LANE_W] = d_in[P*LANE_W +: LANE_W];
      assign swapped_be[i]                 = be_in[P];
   end

   assign d_out  = en ? swapped_d  : d_in;
   assign be_out = en ? swapped_be : be_in;
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
   parameter int W = 36
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         s_valid,
   output logic         s_ready,
   input  logic [W-1:0] s_payload,
   output logic         m_valid,
   input  logic         m_ready,
   output logic [W-1:0] m_payload
);
   if (W < 1) begin : g_bad_w
      $error("stage_reg: W must be positive");
   end

   logic         full_q;
   logic [W-1:0] hold_q;

   assign s_ready   = !full_q || m_ready;
   assign m_valid   = full_q;
   assign m_payload = hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         hold_q <= '0;
      end else begin
         if (s_valid && s_ready) begin
            full_q <= 1'b1;
            hold_q <= s_payload;
         end else if (m_ready) begin
            full_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dma_lane_swap.sv
module dma_lane_swap
   import dma_swap_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              src_width,
   input  logic                    src_bxch,
   input  logic [1:0]              dst_width,
   input  logic                    dst_bxch,
   input  logic                    dst_hxch,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANES*LANE_W-1:0] in_data,
   input  logic [LANES-1:0]        in_be,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [LANES*LANE_W-1:0] out_data,
   output logic [LANES-1:0]        out_be
);
   localparam int DW = LANES * LANE_W;
   localparam int PW = DW + LANES;

   if (LANES != 4) begin : g_bad_lanes
      $error("dma_lane_swap: LANES must be 4");
   end

   logic en_src, en_db, en_dh;
   always_comb begin
      en_src = src_bxch && (dw_code_e'(src_width) == DW_WORD);
      en_db  = dst_bxch && ((dw_code_e'(dst_width) == DW_HALF) ||
                            (dw_code_e'(dst_width) == DW_WORD));
      en_dh  = dst_hxch && (dw_code_e'(dst_width) == DW_WORD);
   end

   logic [DW-1:0]    d_s, d_b, d_h;
   logic [LANES-1:0] e_s, e_b, e_h;

   lane_permute #(.LANE_W(LANE_W), .LANES(LANES), .KIND(PERM_MID)) u_src (
      .en(en_src), .d_in(in_data), .be_in(in_be), .d_out(d_s), .be_out(e_s));

   lane_permute #(.LANE_W(LANE_W), .LANES(LANES), .KIND(PERM_BYTE)) u_dbyte (
      .en(en_db), .d_in(d_s), .be_in(e_s), .d_out(d_b), .be_out(e_b));

   lane_permute #(.LANE_W(LANE_W), .LANES(LANES), .KIND(PERM_HALF)) u_dhalf (
      .en(en_dh), .d_in(d_b), .be_in(e_b), .d_out(d_h), .be_out(e_h));

   logic [PW-1:0] pay_out;

   stage_reg #(.W(PW)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .s_valid(in_valid), .s_ready(in_ready), .s_payload({e_h, d_h}),
      .m_valid(out_valid), .m_ready(out_ready), .m_payload(pay_out));

   assign out_data = pay_out[DW-1:0];
   assign out_be   = pay_out[PW-1:DW];
endmodule

// File: rtl/dma_lane_swap_chk.sv
module dma_lane_swap_chk #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic [LANES*LANE_W-1:0] in_data,
   input logic [LANES-1:0]        in_be,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [LANES*LANE_W-1:0] out_data,
   input logic [LANES-1:0]        out_be
);
   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be)));

   // R10
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R12
   empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   // R9
   be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> ($countones(out_be) == $countones($past(in_be))));

   // R2
   data_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> ($countones(out_data) == $countones($past(in_data))));
endmodule

bind dma_lane_swap dma_lane_swap_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_data(in_data), .in_be(in_be), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .out_be(out_be));

// File: tb/dma_lane_swap_test.sv
module dma_lane_swap_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  src_width = 2'b00, dst_width = 2'b00;
   logic        src_bxch = 1'b0, dst_bxch = 1'b0, dst_hxch = 1'b0;
   logic        in_valid = 1'b0, out_ready = 1'b1;
   logic [31:0] in_data = '0;
   logic [3:0]  in_be = '0;
   logic        in_ready, out_valid;
   logic [31:0] out_data;
   logic [3:0]  out_be;

   int checks = 0, errors = 0, cycles = 0;
   logic [35:0] q_exp[$];
   string       q_tag[$];
   string       cur_tag = "R2";

   always #2 clk = ~clk;

   dma_lane_swap uut (
      .clk(clk), .rst_n(rst_n), .src_width(src_width), .src_bxch(src_bxch),
      .dst_width(dst_width), .dst_bxch(dst_bxch), .dst_hxch(dst_hxch),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_be(in_be),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_be(out_be));

   function automatic logic [35:0] model(input logic [31:0] d, input logic [3:0] be,
                                         input logic [1:0] sw, input logic sb,
                                         input logic [1:0] dw, input logic db, input logic dh);
      logic [7:0] b[4];
      logic       e[4];
      logic [7:0] tb;
      logic       te;
      for (int k = 0; k < 4; k++) begin b[k] = d[8*k +: 8]; e[k] = be[k]; end
      if (sw == 2'b10 && sb) begin
         tb = b[1]; b[1] = b[2]; b[2] = tb; te = e[1]; e[1] = e[2]; e[2] = te;
      end
      if ((dw == 2'b01 || dw == 2'b10) && db) begin
         for (int k = 0; k < 4; k += 2) begin
            tb = b[k]; b[k] = b[k+1]; b[k+1] = tb; te = e[k]; e[k] = e[k+1]; e[k+1] = te;
         end
      end
      if (dw == 2'b10 && dh) begin
         for (int k = 0; k < 2; k++) begin
            tb = b[k]; b[k] = b[k+2]; b[k+2] = tb; te = e[k]; e[k] = e[k+2]; e[k+2] = te;
         end
      end
      for (int k = 0; k < 4; k++) begin model[8*k +: 8] = b[k]; model[32+k] = e[k]; end
   endfunction

   task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the queue model, away from the rising edge
   always @(negedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
      if (!rst_n) begin
         check(out_valid == 1'b0, "R1 reset", {35'd0, out_valid}, 36'd0);
      end else begin
         check(out_valid == (q_exp.size() != 0), "R10 valid", {35'd0, out_valid},
               {35'd0, q_exp.size() != 0});
         check(in_ready == ((q_exp.size() == 0) || out_ready), "R12 ready",
               {35'd0, in_ready}, {35'd0, (q_exp.size() == 0) || out_ready});
         if (out_valid && q_exp.size() != 0)
            check({out_be, out_data} == q_exp[0], q_tag[0], {out_be, out_data}, q_exp[0]);
         if (out_valid && out_ready && q_exp.size() != 0) begin
            void'(q_exp.pop_front()); void'(q_tag.pop_front());
         end
         if (in_valid && in_ready) begin
            q_exp.push_back(model(in_data, in_be, src_width, src_bxch, dst_width, dst_bxch, dst_hxch));
            q_tag.push_back(cur_tag);
         end
      end
   end

   task automatic send(input string tag, input logic [1:0] sw, input logic sb,
                       input logic [1:0] dw, input logic db, input logic dh,
                       input logic [31:0] d, input logic [3:0] be);
      cur_tag = tag;
      src_width = sw; src_bxch = sb; dst_width = dw; dst_bxch = db; dst_hxch = dh;
      in_data = d; in_be = be; in_valid = 1'b1;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 checked while reset held and in the first cycle after release
      send("R2 src mid swap",       2'b10, 1, 2'b00, 0, 0, 32'h44332211, 4'b0010);
      send("R3 src half ignored",   2'b01, 1, 2'b00, 0, 0, 32'h44332211, 4'b0100);
      send("R3 src byte ignored",   2'b00, 1, 2'b00, 0, 0, 32'hA1B2C3D4, 4'b1111);
      send("R3 src rsvd ignored",   2'b11, 1, 2'b00, 0, 0, 32'h0F1E2D3C, 4'b0110);
      send("R4 dst byte half-wd",   2'b00, 0, 2'b01, 1, 0, 32'h44332211, 4'b0001);
      send("R4 dst byte word",      2'b00, 0, 2'b10, 1, 0, 32'h88776655, 4'b1000);
      send("R5 dst byte ignored",   2'b00, 0, 2'b00, 1, 1, 32'h44332211, 4'b0011);
      send("R5 dst rsvd ignored",   2'b00, 0, 2'b11, 1, 1, 32'hCAFEF00D, 4'b1100);
      send("R6 dst half swap",      2'b00, 0, 2'b10, 0, 1, 32'h44332211, 4'b0011);
      send("R6 half ignored at hw", 2'b00, 0, 2'b01, 0, 1, 32'h44332211, 4'b0011);
      send("R7 full reverse",       2'b00, 0, 2'b10, 1, 1, 32'h44332211, 4'b0001);
      send("R8 src then dst byte",  2'b10, 1, 2'b01, 1, 0, 32'h44332211, 4'b0010);
      send("R8 src then all dst",   2'b10, 1, 2'b10, 1, 1, 32'h44332211, 4'b0101);
      send("R9 be follows data",    2'b10, 1, 2'b10, 0, 1, 32'hDEADBEEF, 4'b1010);
      // R11 back-pressure and R10 throughput with random traffic
      fork
         begin
            for (int n = 0; n < 400; n++)
               send("R11 stall random", 2'($urandom), 1'($urandom), 2'($urandom),
                    1'($urandom), 1'($urandom), $urandom, 4'($urandom));
         end
         begin
            for (int n = 0; n < 1500; n++) begin
               @(posedge clk); #1 out_ready = 1'($urandom);
            end
         end
      join
      @(posedge clk); #1 out_ready = 1'b1;
      repeat (4) @(posedge clk);
      check(q_exp.size() == 0, "R11 no loss", {32'd0, 4'(q_exp.size())}, 36'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule